// File: doc/BRIEF.md
# Halfword-Swapping Peripheral DMA Path

This block moves data between a peripheral that works in 16-bit, byte-exchanged halfwords and a 32-bit memory port. The peripheral presents a request: an address, a byte count, a direction and a flag that asks for native byte order. The block ORs a base value into the request address to form the memory address. It then runs one memory beat per halfword, or per byte where native order leaves an odd address or an odd last byte. Each beat uses a request/grant handshake and byte enables on the 32-bit bus.

In swapping mode (native flag low), the block clears bit 0 of both the address and the length. It exchanges the two bytes of every halfword in both directions. Writes go out as bursts of at most `CHUNK_BYTES` bytes, and there is one idle cycle between bursts. In native mode, data passes straight through, with no alignment forcing and no bursting. A one-cycle done pulse marks the end of every transfer, including a transfer that is empty.

Top module: `dma16_swap_path`

## Requirements
- R1: The memory address of the first beat equals the request address bitwise OR the `base_addr` input. Later beats advance it by the bytes moved per beat.
- R2: When `req_native` is 0, bit 0 of both the formed address and the byte count is cleared before the transfer starts.
- R3: On a swapping write, each peripheral halfword {hi,lo} is placed in memory with byte lane A = hi and lane A+1 = lo. A is `mem_addr[1:0]`, and only those two bits of `mem_be` are set.
- R4: On a swapping read, the halfword returned on `rd_data` is {lane A, lane A+1}. On a native read it is {lane A+1, lane A}. A one-byte native read returns {8'h00, lane A}.
- R5: On a swapping write, `mem_last` marks the beat that completes each 64-byte burst and the final beat of the transfer.
- R6: In the cycle after any beat granted with `mem_last` high, `mem_req` is low.
- R7: In native mode, no forcing is applied. A beat moves 2 bytes when the address is even and at least 2 bytes remain, and 1 byte otherwise. A 1-byte write uses `wr_data[7:0]`. `mem_last` is set only on the final beat.
- R8: `done` is high for exactly one cycle, in the cycle after the final beat is granted.
- R9: A request whose byte count is zero after R2 issues no memory beat, and it raises `done` in the cycle after acceptance.
- R10: `req_ready` is low from acceptance until the cycle after the final beat.
- R11: While `mem_req` is high and `mem_gnt` low, `mem_req` stays high and `mem_addr` stays stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_addr | input | ADDR_W | High address bits ORed into every request |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| req_native | input | 1 | 1 = native order, no swap, no forcing, no bursting |
| req_addr | input | ADDR_W | Request byte address |
| req_len | input | LEN_W | Request byte count |
| wr_valid | input | 1 | Peripheral write halfword available |
| wr_ready | output | 1 | Write halfword consumed this cycle |
| wr_data | input | 16 | Peripheral write halfword |
| rd_valid | output | 1 | Read halfword delivered this cycle |
| rd_data | output | 16 | Read halfword to the peripheral |
| mem_req | output | 1 | Memory beat request |
| mem_gnt | input | 1 | Memory beat accepted (read data valid) |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with the grant |
| mem_last | output | 1 | Beat ends a burst or the transfer |
| done | output | 1 | Transfer-complete pulse |

## Verification
The assertions assume that a peripheral write source, once it raises `wr_valid` during a transfer, holds it until `wr_ready`. They also assume that memory returns read data in the same cycle as the grant. Without these, R11 could not hold on a write. The stimulus presents the next halfword in every cycle after the previous one is consumed and never withdraws it. The memory model grants on a fixed stall pattern that is independent of the request. `base_addr` and the request fields are changed only while the block is idle.

// File: rtl/dma16_pkg.sv
package dma16_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } dma16_state_e;

    localparam int MEM_BYTES = 4;
    localparam int HW_BITS   = 16;
endpackage

// File: rtl/dma16_req_norm.sv
module dma16_req_norm #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              native,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [LEN_W-1:0]  eff_len,
    output logic              empty
);
    logic [ADDR_W-1:0] ored;

    always_comb begin
        ored     = req_addr | base_addr;
        eff_addr = ored;
        eff_len  = req_len;
        if (!native) begin
            eff_addr[0] = 1'b0;
            eff_len[0]  = 1'b0;
        end
        empty = (eff_len == '0);
    end
endmodule

// File: rtl/dma16_lane_map.sv
module dma16_lane_map
    import dma16_pkg::*;
(
    input  logic [1:0]             offset,
    input  logic                   size2,
    input  logic                   swap,
    input  logic [HW_BITS-1:0]     wr_hw,
    input  logic [8*MEM_BYTES-1:0] rdata,
    output logic [MEM_BYTES-1:0]   be,
    output logic [8*MEM_BYTES-1:0] wdata,
    output logic [HW_BITS-1:0]     rd_hw
);
    localparam int LANES = MEM_BYTES;

    logic [7:0] lo_byte;
    logic [7:0] hi_byte;
    logic [7:0] rd_b0;
    logic [7:0] rd_b1;
    logic [1:0] offset_p1;

    always_comb begin
        offset_p1 = offset + 2'd1;
        if (size2 && swap) begin
            lo_byte = wr_hw[15:8];
            hi_byte = wr_hw[7:0];
        end else begin
            lo_byte = wr_hw[7:0];
            hi_byte = wr_hw[15:8];
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            be[k] = (offset == 2'(k)) || (size2 && (offset_p1 == 2'(k)));
            wdata[8*k +: 8] = (offset == 2'(k)) ? lo_byte : hi_byte;
        end
    end

    always_comb begin
        rd_b0 = rdata[8*offset +: 8];
        rd_b1 = rdata[8*offset_p1 +: 8];
        if (!size2)
            rd_hw = {8'h00, rd_b0};
        else if (swap)
            rd_hw = {rd_b0, rd_b1};
        else
            rd_hw = {rd_b1, rd_b0};
    end
endmodule

// File: rtl/dma16_swap_path.sv
module dma16_swap_path
    import dma16_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 12,
    parameter int CHUNK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_native,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [15:0]       wr_data,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              mem_last,
    output logic              done
);
    localparam int CNT_W = $clog2(CHUNK_BYTES) + 2;

    typedef struct packed {
        dma16_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [CNT_W-1:0]  cnt;
        logic              we;
        logic              swap;
        logic              done;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] eff_addr;
    logic [LEN_W-1:0]  eff_len;
    logic              eff_empty;
    logic              size2;
    logic [LEN_W-1:0]  step;
    logic              fire;
    logic              final_beat;
    logic              chunk_end;

    dma16_req_norm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_norm (
        .req_addr (req_addr),
        .base_addr(base_addr),
        .req_len  (req_len),
        .native   (req_native),
        .eff_addr (eff_addr),
        .eff_len  (eff_len),
        .empty    (eff_empty)
    );

    dma16_lane_map u_lanes (
        .offset(q.addr[1:0]),
        .size2 (size2),
        .swap  (q.swap),
        .wr_hw (wr_data),
        .rdata (mem_rdata),
        .be    (mem_be),
        .wdata (mem_wdata),
        .rd_hw (rd_data)
    );

    always_comb begin
        d = q;
        d.done = 1'b0;

        size2      = !q.addr[0] && (q.rem >= LEN_W'(2));
        step       = size2 ? LEN_W'(2) : LEN_W'(1);
        final_beat = (q.rem == step);
        chunk_end  = q.we && q.swap &&
                     ((q.cnt + CNT_W'(step)) == CNT_W'(CHUNK_BYTES));

        req_ready = (q.st == ST_IDLE);
        mem_req   = (q.st == ST_XFER) && (q.we ? wr_valid : 1'b1);
        mem_we    = q.we;
        mem_addr  = q.addr;
        mem_last  = final_beat || chunk_end;
        fire      = mem_req && mem_gnt;
        wr_ready  = fire && q.we;
        rd_valid  = fire && !q.we;

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr = eff_addr;
                    d.rem  = eff_len;
                    d.cnt  = '0;
                    d.we   = req_write;
                    d.swap = !req_native;
                    if (eff_empty)
                        d.done = 1'b1;
                    else
                        d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (fire) begin
                    d.addr = q.addr + ADDR_W'(step);
                    d.rem  = q.rem - step;
                    d.cnt  = q.cnt + CNT_W'(step);
                    if (final_beat) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else if (chunk_end) begin
                        d.st  = ST_GAP;
                        d.cnt = '0;
                    end
                end
            end
            ST_GAP:  d.st = ST_XFER;
            default: d.st = ST_IDLE;
        endcase

        done = q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, addr: '0, rem: '0, cnt: '0,
                   we: 1'b0, swap: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dma16_chk.sv
module dma16_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic              mem_last,
    input logic              done
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R6
    burst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_last) |=> !mem_req);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R7
    lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) >= 1 && $countones(mem_be) <= 2));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && req_ready));
endmodule

bind dma16_swap_path dma16_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .mem_last (mem_last),
    .done     (done)
);

// File: tb/sim_dma16_swap_path.sv
module sim_dma16_swap_path;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_native = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [15:0]   wr_data = '0;
    logic          rd_valid;
    logic [15:0]   rd_data;
    logic          mem_req;
    logic          mem_gnt = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;
    logic          mem_last;
    logic          done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma16_swap_path #(.ADDR_W(AW), .LEN_W(LW), .CHUNK_BYTES(64)) u0 (
        .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_native(req_native), .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_last(mem_last), .done(done)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic          we;
        logic [3:0]    be;
        logic [31:0]   wdata;
        logic [15:0]   rdhw;
        logic          last;
        logic          fin;
    } beat_t;

    beat_t       exp_q[$];
    logic [15:0] wr_q[$];
    int          checks = 0;
    int          fails = 0;
    int          beats_seen = 0;
    int          done_seen = 0;
    bit          wr_took = 0;
    bit          prev_last = 0;
    bit          prev_fin = 0;
    bit          prev_stall = 0;
    logic [AW-1:0] stall_addr = '0;
    int          cyc = 0;

    function automatic logic [7:0] fbyte(input logic [AW-1:0] x);
        logic [AW-1:0] t;
        t = x * 7 + 3;
        return t[7:0];
    endfunction

    always_comb begin
        for (int k = 0; k < 4; k++)
            mem_rdata[8*k +: 8] = fbyte({mem_addr[AW-1:2], 2'b00} + AW'(k));
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // memory grant pattern, independent of the request
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        mem_gnt = (cyc % 3) != 1;
    end

    // peripheral write feeder: holds each halfword until consumed
    initial forever begin
        @(posedge clk); #1;
        if (wr_took && wr_q.size() > 0) void'(wr_q.pop_front());
        wr_took = 0;
        wr_valid = wr_q.size() > 0;
        wr_data = (wr_q.size() > 0) ? wr_q[0] : 16'h0;
    end

    // monitor / scoreboard
    initial forever begin
        @(negedge clk);
        if (!rst_n) continue;
        if (prev_stall)
            check(mem_req && mem_addr == stall_addr, "R11", "held request",
                  mem_addr, stall_addr);
        if (prev_last)
            check(!mem_req, "R6", "idle after last beat", 32'(mem_req), 0);
        if (prev_fin)
            check(done, "R8", "done after final beat", 32'(done), 1);
        else
            check(!done || beats_seen == 0 || exp_q.size() == 0, "R8",
                  "spurious done", 32'(done), 0);
        if (mem_req)
            check(!req_ready, "R10", "ready while busy", 32'(req_ready), 0);
        prev_stall = mem_req && !mem_gnt;
        stall_addr = mem_addr;
        prev_last = 0;
        prev_fin = 0;
        if (done) done_seen++;
        if (mem_req && mem_gnt) begin
            beats_seen++;
            if (mem_we) wr_took = 1;
            if (exp_q.size() == 0) begin
                check(0, "R9", "unexpected beat", mem_addr, 0);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.addr, "R1", "beat address", mem_addr, e.addr);
                check(mem_be == e.be, "R7", "byte enables", 32'(mem_be), 32'(e.be));
                check(mem_last == e.last, "R5", "last flag", 32'(mem_last), 32'(e.last));
                if (e.we)
                    check(mem_wdata == e.wdata, "R3", "write data", mem_wdata, e.wdata);
                else
                    check(rd_valid && rd_data == e.rdhw, "R4", "read halfword",
                          32'(rd_data), 32'(e.rdhw));
                prev_last = mem_last;
                prev_fin = e.fin;
            end
        end
    end

    // driver: builds expected beats from the requirements and issues the request
    task automatic run(input bit we, input logic [AW-1:0] base,
                       input logic [AW-1:0] addr, input int len, input bit native,
                       input string tag);
        logic [AW-1:0] a;
        int rem, cnt, n, d0, sz, idx;
        bit sw;
        a = addr | base;
        rem = len;
        sw = !native;
        if (sw) begin
            a[0] = 1'b0;
            rem = rem & ~1;
        end
        cnt = 0; idx = 0; n = 0;
        while (rem > 0) begin
            beat_t b;
            logic [15:0] hw;
            logic [7:0] lo, hi;
            int off;
            sz = (!a[0] && rem >= 2) ? 2 : 1;
            off = int'(a[1:0]);
            hw = 16'h1357 + 16'(idx * 16'h0529);
            b.addr = a; b.we = we;
            b.be = (sz == 2) ? (4'b0011 << off) : (4'b0001 << off);
            lo = (sz == 2 && sw) ? hw[15:8] : hw[7:0];
            hi = (sz == 2 && sw) ? hw[7:0] : hw[15:8];
            b.wdata = '0;
            for (int k = 0; k < 4; k++)
                b.wdata[8*k +: 8] = (k == off) ? lo : hi;
            if (sz == 1) b.rdhw = {8'h00, fbyte(a)};
            else if (sw) b.rdhw = {fbyte(a), fbyte(a + 1)};
            else b.rdhw = {fbyte(a + 1), fbyte(a)};
            b.fin = (rem == sz);
            b.last = b.fin || (we && sw && (cnt + sz == 64));
            cnt = (b.last) ? 0 : cnt + sz;
            if (we) wr_q.push_back(hw);
            exp_q.push_back(b);
            a = a + AW'(sz);
            rem -= sz;
            idx++;
        end
        n = idx;
        beats_seen = 0;
        d0 = done_seen;
        @(posedge clk); #1;
        base_addr = base; req_addr = addr; req_len = LW'(len);
        req_write = we; req_native = native; req_valid = 1;
        @(posedge clk); #1;
        req_valid = 0;
        if (n == 0) begin
            @(negedge clk);
            check(done && !mem_req, "R9", {tag, " immediate done"}, 32'(done), 1);
        end
        for (int t = 0; t < 2000 && done_seen == d0; t++) @(negedge clk);
        check(done_seen == d0 + 1, "R8", {tag, " done count"}, 32'(done_seen - d0), 1);
        check(beats_seen == n, "R2", {tag, " beat count"}, 32'(beats_seen), 32'(n));
        check(exp_q.size() == 0, "R5", {tag, " pending beats"}, 32'(exp_q.size()), 0);
        exp_q.delete();
        wr_q.delete();
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(req_ready && !mem_req && !done, "R10", "reset state",
              {29'b0, req_ready, mem_req, done}, 32'h4);
        rst_n = 1;
        // R1 R3: swapping write with base OR
        run(1, 32'h4000_0000, 32'h0000_0100, 8, 0, "R1 R3 swap write");
        // R2: odd address and length forced even
        run(1, 32'h0000_0000, 32'h0000_0201, 7, 0, "R2 odd swap write");
        // R5 R6: 150 bytes in 64/64/22 bursts
        run(1, 32'h0010_0000, 32'h0000_0040, 150, 0, "R5 chunked write");
        // R7: native write, odd start and length, no bursting
        run(1, 32'h0000_0000, 32'h0000_0301, 5, 1, "R7 native write");
        run(1, 32'h0000_0000, 32'h0000_0400, 100, 1, "R7 native long");
        // R4: reads both modes
        run(0, 32'h0000_1000, 32'h0000_0012, 6, 0, "R4 swap read");
        run(0, 32'h0000_0000, 32'h0000_0007, 3, 1, "R4 native read");
        run(0, 32'h0000_0000, 32'h0000_0080, 130, 0, "R4 long swap read");
        // R1: overlapping base bits
        run(1, 32'h0000_0F0C, 32'h0000_0033, 4, 0, "R1 overlap base");
        // R9: zero length and swap-forced zero
        run(1, 32'h0, 32'h0000_0010, 0, 0, "R9 zero");
        run(0, 32'h0, 32'h0000_0011, 1, 0, "R9 forced zero");
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end
endmodule